// File: doc/BRIEF.md
# Binary/Decimal Add-With-Carry Execution Unit

This unit carries out one 8-bit add-with-carry once the operand byte has already been fetched. The caller supplies the opcode, the operand M, the current accumulator, the X index, the carry flag, a decimal-mode select and a memory-target select. With the memory target off, the unit forms A + M + C and returns it as the new accumulator. With the memory target on, the unit reads the byte at address X through a synchronous memory port. It adds that byte to M and C, writes the sum back to the same address and returns the accumulator unchanged.

The sum can be formed in plain binary or in packed two-digit decimal. In decimal mode each nibble is corrected on its own, and the carry means the sum went past 99. On every operation the unit refreshes the sign, overflow, zero and carry flags. For the eight opcode encodings of the instruction, it also reports the instruction length in bytes and the total cycle cost. The memory-target form costs three cycles more than the base figure.

Top module: `carry_add_unit`

## Requirements
- R1: With t_mode=0 and d_mode=0, acc_out becomes (acc_in + operand + c_in) mod 256. done is high for exactly one cycle, which is the first cycle after the clock edge that samples start.
- R2: In binary mode, flag_c is 1 exactly when acc_in/M(X) + operand + c_in exceeds 255.
- R3: In binary mode, flag_n equals bit 7 of the 8-bit sum, and flag_z is 1 exactly when the 8-bit sum is 0.
- R4: In binary mode, flag_v is 1 exactly when both addends have the same bit 7 and the sum's bit 7 differs from it. This is the case where the signed sum leaves the range -128..+127.
- R5: With d_mode=1 and both addends valid packed decimal (each nibble 0..9), the result is the packed decimal form of (value mod 100), and flag_c is 1 exactly when the decimal value exceeds 99.
- R6: With t_mode=1, the sequence runs as follows. mem_rd is high with mem_addr = x_idx in the first cycle after the start edge. mem_wr is high with mem_wdata = mem_rdata + operand + c_in (binary or decimal) in the third cycle. done is high in the fourth cycle. acc_out equals acc_in.
- R7: With t_mode=1, the flags are updated from the sum written to memory, following R2 to R5.
- R8: cycles reports the base count for opcode 0x69=2, 0x65=3, 0x75=4, 0x6D=4, 0x7D=5, 0x79=5, 0x61=6 and 0x71=6, plus 3 when t_mode=1. Any other opcode reports 0.
- R9: inst_len reports 2 for opcodes 0x69, 0x65, 0x75, 0x61 and 0x71, and 3 for 0x6D, 0x7D and 0x79. Any other opcode reports 0.
- R10: busy is high from the cycle after the start edge through the done cycle. A start seen while busy is ignored: there is no second read, no second write and no second done, and the stored byte reflects a single add.
- R11: After reset, busy, done, mem_rd and mem_wr are 0, and acc_out, the four flags, cycles and inst_len are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (accepted only when idle) |
| opcode | input | 8 | Opcode of the instruction being executed |
| operand | input | 8 | Already-fetched operand byte M |
| acc_in | input | 8 | Current accumulator |
| x_idx | input | 8 | X register, memory address for the memory-target form |
| c_in | input | 1 | Carry flag before the operation |
| d_mode | input | 1 | 1 selects packed decimal arithmetic |
| t_mode | input | 1 | 1 selects the memory byte at X as addend and destination |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_out | output | 8 | Accumulator after the operation |
| flag_n | output | 1 | Sign flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| cycles | output | 4 | Total cycle cost of the instruction |
| inst_len | output | 2 | Instruction length in bytes |
| mem_addr | output | 8 | Memory address (X) |
| mem_rd | output | 1 | Memory read strobe, data returned the next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after mem_rd |

## Verification
The hardest case to reach from the ports is a fresh start that arrives while a read-modify-write is still running. Reaching it needs start raised exactly in the read and compute cycles, against a memory that answers one cycle late. The bench models the synchronous memory itself and re-pulses start on the falling edges inside the busy window. It then counts write strobes and done pulses and reads the stored byte back, to confirm that only one add landed. Decimal carries at the 99 boundary and binary overflow at 0x7F/0x80 are driven through both destinations.

// File: rtl/carry_add_pkg.sv
package carry_add_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_READ  = 3'd1,
    S_CALC  = 3'd2,
    S_WRITE = 3'd3,
    S_DONE  = 3'd4
  } cau_state_e;

  // Base cycle cost of each supported encoding; 0 marks an unsupported opcode.
  function automatic logic [3:0] base_cycles(input logic [7:0] op);
    case (op)
      8'h69:        return 4'd2;
      8'h65:        return 4'd3;
      8'h75, 8'h6D: return 4'd4;
      8'h7D, 8'h79: return 4'd5;
      8'h61, 8'h71: return 4'd6;
      default:      return 4'd0;
    endcase
  endfunction

  // Instruction length in bytes; 0 marks an unsupported opcode.
  function automatic logic [1:0] op_bytes(input logic [7:0] op);
    case (op)
      8'h6D, 8'h7D, 8'h79:               return 2'd3;
      8'h69, 8'h65, 8'h75, 8'h61, 8'h71: return 2'd2;
      default:                           return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/cau_decode.sv
module cau_decode #(
  parameter int CYC_W   = 4,
  parameter int T_EXTRA = 3
) (
  input  logic [7:0]       opcode,
  input  logic             t_mode,
  output logic [CYC_W-1:0] cycles,
  output logic [1:0]       inst_len
);
  import carry_add_pkg::*;

  logic [3:0] base;
  logic       known;

  assign base     = base_cycles(opcode);
  assign known    = (base != 4'd0);
  assign inst_len = op_bytes(opcode);

  always_comb begin
    cycles = CYC_W'(base);
    if (known && t_mode) cycles = CYC_W'(base) + CYC_W'(T_EXTRA);
  end
endmodule

// File: rtl/cau_adder.sv
module cau_adder #(
  parameter int DATA_W  = 8,
  parameter bit HAS_BCD = 1'b1
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              dec,
  output logic [DATA_W-1:0] sum,
  output logic              c_out,
  output logic              v_out
);
  localparam int MSB  = DATA_W - 1;
  localparam int NDIG = DATA_W / 4;

  logic [DATA_W:0]   bin_w;
  logic [DATA_W-1:0] dec_sum;
  logic              dec_c;

  assign bin_w = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};

  generate
    if (HAS_BCD) begin : g_bcd
      // Digit-by-digit ripple with +6 correction above nine.
      always_comb begin
        logic [5:0] d;
        logic       cy;
        cy      = cin;
        dec_sum = '0;
        for (int i = 0; i < NDIG; i++) begin
          d = {2'b00, a[4*i +: 4]} + {2'b00, b[4*i +: 4]} + {5'b0, cy};
          if (d > 6'd9) begin
            d  = d + 6'd6;
            cy = 1'b1;
          end else begin
            cy = 1'b0;
          end
          dec_sum[4*i +: 4] = d[3:0];
        end
        dec_c = cy;
      end
    end else begin : g_bin_only
      assign dec_sum = bin_w[MSB:0];
      assign dec_c   = bin_w[DATA_W];
    end
  endgenerate

  assign sum   = dec ? dec_sum : bin_w[MSB:0];
  assign c_out = dec ? dec_c   : bin_w[DATA_W];
  assign v_out = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
endmodule

// File: rtl/cau_ctrl.sv
module cau_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic t_mode,
  output logic accept,
  output logic in_calc,
  output logic load_res,
  output logic busy,
  output logic done,
  output logic mem_rd,
  output logic mem_wr
);
  import carry_add_pkg::*;

  cau_state_e st, st_nx;

  assign accept   = (st == S_IDLE) && start;
  assign in_calc  = (st == S_CALC);
  assign load_res = (accept && !t_mode) || in_calc;
  assign busy     = (st != S_IDLE);
  assign done     = (st == S_DONE);
  assign mem_rd   = (st == S_READ);
  assign mem_wr   = (st == S_WRITE);

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:  if (start) st_nx = t_mode ? S_READ : S_DONE;
      S_READ:  st_nx = S_CALC;
      S_CALC:  st_nx = S_WRITE;
      S_WRITE: st_nx = S_DONE;
      S_DONE:  st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= st_nx;
  end
endmodule

// File: rtl/carry_add_unit.sv
module carry_add_unit #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 8,
  parameter int CYC_W   = 4,
  parameter int T_EXTRA = 3,
  parameter bit HAS_BCD = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [ADDR_W-1:0] x_idx,
  input  logic              c_in,
  input  logic              d_mode,
  input  logic              t_mode,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] acc_out,
  output logic              flag_n,
  output logic              flag_v,
  output logic              flag_z,
  output logic              flag_c,
  output logic [CYC_W-1:0]  cycles,
  output logic [1:0]        inst_len,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int MSB = DATA_W - 1;

  // Named internal events, also used by the bound checker.
  logic              accept, in_calc, load_res;
  logic              rmw_q, dec_q, c_q;
  logic [DATA_W-1:0] m_q, res_q;
  logic [ADDR_W-1:0] x_q;

  logic [DATA_W-1:0] add_a, add_b, add_sum;
  logic              add_cin, add_dec, add_c, add_v;
  logic [CYC_W-1:0]  cyc_w;
  logic [1:0]        len_w;

  cau_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .t_mode   (t_mode),
    .accept   (accept),
    .in_calc  (in_calc),
    .load_res (load_res),
    .busy     (busy),
    .done     (done),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr)
  );

  cau_decode #(.CYC_W(CYC_W), .T_EXTRA(T_EXTRA)) u_dec (
    .opcode   (opcode),
    .t_mode   (t_mode),
    .cycles   (cyc_w),
    .inst_len (len_w)
  );

  // Idle: operands straight from the ports. Compute state: memory byte plus latched values.
  assign add_a   = in_calc ? mem_rdata : acc_in;
  assign add_b   = in_calc ? m_q       : operand;
  assign add_cin = in_calc ? c_q       : c_in;
  assign add_dec = in_calc ? dec_q     : d_mode;

  cau_adder #(.DATA_W(DATA_W), .HAS_BCD(HAS_BCD)) u_add (
    .a     (add_a),
    .b     (add_b),
    .cin   (add_cin),
    .dec   (add_dec),
    .sum   (add_sum),
    .c_out (add_c),
    .v_out (add_v)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q      <= '0;
      x_q      <= '0;
      c_q      <= 1'b0;
      dec_q    <= 1'b0;
      rmw_q    <= 1'b0;
      acc_out  <= '0;
      cycles   <= '0;
      inst_len <= '0;
    end else if (accept) begin
      m_q      <= operand;
      x_q      <= x_idx;
      c_q      <= c_in;
      dec_q    <= d_mode;
      rmw_q    <= t_mode;
      acc_out  <= t_mode ? acc_in : add_sum;
      cycles   <= cyc_w;
      inst_len <= len_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      flag_n <= 1'b0;
      flag_v <= 1'b0;
      flag_z <= 1'b0;
      flag_c <= 1'b0;
    end else if (load_res) begin
      res_q  <= add_sum;
      flag_n <= add_sum[MSB];
      flag_v <= add_v;
      flag_z <= (add_sum == '0);
      flag_c <= add_c;
    end
  end

  assign mem_addr  = x_q;
  assign mem_wdata = res_q;
endmodule

// File: rtl/carry_add_unit_chk.sv
module carry_add_unit_chk #(
  parameter int DATA_W = 8,
  parameter int CYC_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              flag_n,
  input logic              flag_z,
  input logic              rmw_q,
  input logic              dec_q,
  input logic [DATA_W-1:0] res_q,
  input logic [CYC_W-1:0]  cycles
);
  p_read_before_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd, 2));

  p_done_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> done);

  p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr && !done));

  p_zero_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !dec_q) |-> (flag_z == (res_q == '0)));

  p_sign_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !dec_q) |-> (flag_n == res_q[DATA_W-1]));

  p_rmw_cost_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rmw_q && (cycles != '0)) |-> (cycles >= CYC_W'(5)));

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);
endmodule

bind carry_add_unit carry_add_unit_chk #(.DATA_W(DATA_W), .CYC_W(CYC_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .mem_rd (mem_rd),
  .mem_wr (mem_wr),
  .flag_n (flag_n),
  .flag_z (flag_z),
  .rmw_q  (rmw_q),
  .dec_q  (dec_q),
  .res_q  (res_q),
  .cycles (cycles)
);

// File: tb/carry_add_unit_bench.sv
`timescale 1ns/1ps
module carry_add_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] opcode = 8'h69, operand = '0, acc_in = '0, x_idx = '0;
  logic       c_in = 1'b0, d_mode = 1'b0, t_mode = 1'b0;
  logic       busy, done, flag_n, flag_v, flag_z, flag_c, mem_rd, mem_wr;
  logic [7:0] acc_out, mem_addr, mem_wdata;
  logic [7:0] mem_rdata = '0;
  logic [3:0] cycles;
  logic [1:0] inst_len;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  carry_add_unit u_carry_add_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .operand(operand),
    .acc_in(acc_in), .x_idx(x_idx), .c_in(c_in), .d_mode(d_mode), .t_mode(t_mode),
    .busy(busy), .done(done), .acc_out(acc_out), .flag_n(flag_n), .flag_v(flag_v),
    .flag_z(flag_z), .flag_c(flag_c), .cycles(cycles), .inst_len(inst_len),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // Synchronous memory model with a preload path.
  logic [7:0] ram [256];
  logic       pl_en = 1'b0;
  logic [7:0] pl_addr = '0, pl_data = '0;
  always @(posedge clk) begin
    if (pl_en) ram[pl_addr] <= pl_data;
    else if (mem_wr) ram[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= ram[mem_addr];
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference arithmetic: returns {carry, sum}.
  function automatic logic [8:0] ref_bin(input int a, input int m, input int c);
    int s;
    s = a + m + c;
    return {(s > 255) ? 1'b1 : 1'b0, 8'(s % 256)};
  endfunction

  function automatic logic [8:0] ref_dec(input logic [7:0] a, input logic [7:0] m, input int c);
    int s;
    s = (a[7:4] * 10 + a[3:0]) + (m[7:4] * 10 + m[3:0]) + c;
    return {(s > 99) ? 1'b1 : 1'b0, 4'((s % 100) / 10), 4'(s % 10)};
  endfunction

  function automatic bit ref_v(input logic [7:0] a, input logic [7:0] m, input int c);
    int s;
    s = $signed(a) + $signed(m) + c;
    return (s > 127) || (s < -128);
  endfunction

  task automatic preload(input logic [7:0] addr, input logic [7:0] val);
    @(negedge clk);
    pl_en = 1'b1; pl_addr = addr; pl_data = val;
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  // Starts one operation and waits for done. lat = falling edges from start edge to done.
  int lat, wr_cnt, rd_cnt, done_cnt;
  logic [7:0] rd_addr;
  task automatic run_op(input logic [7:0] op, input logic [7:0] a, input logic [7:0] m,
                        input logic c, input logic d, input logic t, input logic [7:0] x,
                        input bit restart);
    @(negedge clk);
    opcode = op; acc_in = a; operand = m; c_in = c; d_mode = d; t_mode = t; x_idx = x;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1; wr_cnt = 0; rd_cnt = 0; done_cnt = 0; rd_addr = '0;
    while (!done && lat < 20) begin
      if (mem_rd) begin rd_cnt++; rd_addr = mem_addr; end
      if (mem_wr) wr_cnt++;
      start = restart && (lat < 3);
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    if (done) done_cnt = 1;
    // Watch a few more cycles for a spurious second operation.
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (done) done_cnt++;
      if (mem_wr) wr_cnt++;
      if (mem_rd) rd_cnt++;
    end
  endtask

  task automatic t_reset();
    chk("R11 busy", busy, 0);
    chk("R11 done", done, 0);
    chk("R11 mem_rd", mem_rd, 0);
    chk("R11 mem_wr", mem_wr, 0);
    chk("R11 acc_out", acc_out, 0);
    chk("R11 flags", {flag_n, flag_v, flag_z, flag_c}, 0);
    chk("R11 cycles", cycles, 0);
    chk("R11 inst_len", inst_len, 0);
  endtask

  task automatic t_binary(input logic [7:0] a, input logic [7:0] m, input logic c);
    logic [8:0] e;
    e = ref_bin(a, m, c);
    run_op(8'h69, a, m, c, 1'b0, 1'b0, 8'h00, 1'b0);
    chk("R1 latency", lat, 1);
    chk("R1 single done", done_cnt, 1);
    chk("R1 acc", acc_out, e[7:0]);
    chk("R2 carry", flag_c, e[8]);
    chk("R3 sign", flag_n, e[7]);
    chk("R3 zero", flag_z, (e[7:0] == 0));
    chk("R4 overflow", flag_v, ref_v(a, m, c));
  endtask

  task automatic t_decimal(input logic [7:0] a, input logic [7:0] m, input logic c);
    logic [8:0] e;
    e = ref_dec(a, m, c);
    run_op(8'h65, a, m, c, 1'b1, 1'b0, 8'h00, 1'b0);
    chk("R5 dec sum", acc_out, e[7:0]);
    chk("R5 dec carry", flag_c, e[8]);
  endtask

  task automatic t_rmw(input logic [7:0] x, input logic [7:0] mx, input logic [7:0] a,
                       input logic [7:0] m, input logic c, input logic d, input bit restart);
    logic [8:0] e;
    e = d ? ref_dec(mx, m, c) : ref_bin(mx, m, c);
    preload(x, mx);
    run_op(8'h7D, a, m, c, d, 1'b1, x, restart);
    chk("R6 latency", lat, 4);
    chk("R6 read addr", rd_addr, x);
    chk("R6 acc kept", acc_out, a);
    chk("R6 stored", ram[x], e[7:0]);
    chk("R7 carry", flag_c, e[8]);
    if (!d) begin
      chk("R7 sign", flag_n, e[7]);
      chk("R7 zero", flag_z, (e[7:0] == 0));
      chk("R7 overflow", flag_v, ref_v(mx, m, c));
    end
    if (restart) begin
      chk("R10 one read", rd_cnt, 1);
      chk("R10 one write", wr_cnt, 1);
      chk("R10 one done", done_cnt, 1);
    end else begin
      chk("R6 one write", wr_cnt, 1);
    end
  endtask

  task automatic t_cost();
    logic [7:0] ops [8] = '{8'h69, 8'h65, 8'h75, 8'h6D, 8'h7D, 8'h79, 8'h61, 8'h71};
    int base [8] = '{2, 3, 4, 4, 5, 5, 6, 6};
    int lens [8] = '{2, 2, 2, 3, 3, 3, 2, 2};
    for (int i = 0; i < 8; i++) begin
      run_op(ops[i], 8'h01, 8'h02, 1'b0, 1'b0, 1'b0, 8'h10, 1'b0);
      chk("R8 cycles T0", cycles, base[i]);
      chk("R9 length", inst_len, lens[i]);
      run_op(ops[i], 8'h01, 8'h02, 1'b0, 1'b0, 1'b1, 8'h10, 1'b0);
      chk("R8 cycles T1", cycles, base[i] + 3);
    end
    run_op(8'hEA, 8'h01, 8'h02, 1'b0, 1'b0, 1'b1, 8'h10, 1'b0);
    chk("R8 unknown cycles", cycles, 0);
    chk("R9 unknown length", inst_len, 0);
  endtask

  task automatic t_busy();
    run_op(8'h69, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 8'h20, 1'b0);
    // busy seen during the op is checked by sampling a fresh run.
    @(negedge clk);
    opcode = 8'h69; t_mode = 1'b1; x_idx = 8'h21; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 busy after start", busy, 1);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_binary(8'h10, 8'h20, 1'b0);
    t_binary(8'hFF, 8'h01, 1'b0);
    t_binary(8'h7F, 8'h01, 1'b0);
    t_binary(8'h80, 8'h80, 1'b0);
    t_binary(8'h50, 8'h50, 1'b1);
    t_binary(8'hF0, 8'h0F, 1'b1);
    t_decimal(8'h45, 8'h38, 1'b0);
    t_decimal(8'h99, 8'h01, 1'b0);
    t_decimal(8'h58, 8'h46, 1'b1);
    t_decimal(8'h00, 8'h00, 1'b1);
    t_rmw(8'h40, 8'h7F, 8'h11, 8'h01, 1'b0, 1'b0, 1'b0);
    t_rmw(8'h41, 8'hC0, 8'h22, 8'h40, 1'b0, 1'b0, 1'b0);
    t_rmw(8'h42, 8'h75, 8'h33, 8'h25, 1'b1, 1'b1, 1'b0);
    t_rmw(8'h43, 8'h12, 8'h44, 8'h34, 1'b1, 1'b0, 1'b1);
    t_cost();
    t_busy();
    repeat (8) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule